// File: doc/BRIEF.md
# Low-Power-State Indicator Controller

This block sits on the processor side of the interface to an external core voltage regulator. It drives an active-low indicator that, while asserted, promises the regulator that peak core current will stay below a fixed threshold. The regulator can use that promise to move to a more efficient operating point. The core activity logic supplies two requests: a low-demand request, meaning the core wants to enter the low-current regime, and a high-demand request, meaning the core needs to run above the threshold. The block answers the high-demand request with a grant. The core may start high-current activity only while that grant is high.

The controller deasserts the indicator as soon as high demand appears. It raises the grant only after the indicator has been deasserted for a programmable lead time, counted in base-clock cycles and rounded up from the required warning interval. The default is 440 cycles, which is about 3.3 µs at 133 MHz. The same lead time is also the minimum time the indicator stays deasserted. A separate parameter sets the minimum time the indicator stays asserted, with a default of one cycle.

Four states hold the behaviour:
- WARN: indicator deasserted, lead timer running, grant low.
- GRANT: indicator deasserted, grant high.
- HOLD: indicator asserted, minimum-assert timer running.
- LOW: indicator asserted, minimum satisfied.

The transitions are:
- WARN→GRANT when the lead time expires with no low request pending.
- WARN→HOLD when it expires with a low request pending.
- GRANT→HOLD on a low request without a high request.
- HOLD→WARN at the end of the minimum-assert window if high demand arrived during it.
- HOLD→LOW at the end of that window otherwise.
- LOW→WARN on a high request.

Reset enters WARN.

Top module: `lpsi_ctrl`

## Requirements
- R1: While reset is active, `lp_ind_n` is 1 and `hi_grant` is 0. With no low request, `hi_grant` rises exactly LEAD_CYC clock edges after reset is released.
- R2: `lp_ind_n` = 0 means the indicator is asserted (low current promised). `hi_grant` is never 1 while `lp_ind_n` is 0.
- R3: In GRANT, a low request without a high request asserts the indicator and drops the grant at the next edge.
- R4: In GRANT, a high request keeps the grant high and the indicator deasserted, even if a low request is present at the same time.
- R5: A high request while the indicator is asserted and its minimum-assert time is used up deasserts the indicator at the next edge. `hi_grant` then rises exactly LEAD_CYC edges after that deassertion.
- R6: Once asserted, the indicator stays asserted for at least MIN_ASSERT_CYC cycles. A high request arriving earlier, even as a one-cycle pulse, is held, and the indicator deasserts at the edge that ends the window.
- R7: Once deasserted, the indicator stays deasserted for at least LEAD_CYC cycles. A low request seen during this window is held pending, and the indicator asserts at the edge that ends the window, even if the request has since dropped.
- R8: A high request during the lead window cancels any pending low request. The window then ends in GRANT with the indicator never asserted.
- R9: While the indicator is asserted, dropping the low request has no effect. The indicator stays asserted and the grant stays low until a high request arrives.
- R10: `hi_grant` rises only after `lp_ind_n` has been 1 for at least LEAD_CYC consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_req | input | 1 | Core asks to enter the low-current regime |
| high_req | input | 1 | Core needs to run above the current threshold |
| lp_ind_n | output | 1 | Active-low indicator to the voltage regulator |
| hi_grant | output | 1 | High-current activity may proceed |

## Verification
The hardest situations to reach from the ports are requests that land at a particular offset inside a timed window. Examples are a low request in the last cycle of the lead window, or a high pulse that comes and goes before the minimum-assert window closes. Both windows last many cycles at the default parameters. The bench therefore builds the block with a short lead time and a three-cycle minimum assert. It re-enters each window from a known edge and sweeps the arrival offset over every cycle of the window and one past it. For each offset it predicts the edge at which the indicator or the grant must change, as the later of the window end and the request edge plus one.

// File: rtl/lpsi_pkg.sv
package lpsi_pkg;

    // Bit 1 of the encoding is the "indicator asserted" flag, so the pin
    // decodes from a single flop.
    typedef enum logic [1:0] {
        ST_WARN  = 2'b00,
        ST_GRANT = 2'b01,
        ST_HOLD  = 2'b10,
        ST_LOW   = 2'b11
    } lpsi_state_e;

    function automatic int unsigned lpsi_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lpsi_timer.sv
module lpsi_timer #(
    parameter int unsigned CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lpsi_pend.sv
module lpsi_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic in_win,
    input  logic set,
    input  logic kill,
    output logic pend
);

    logic pend_d;

    // Pending flag lives only inside its window; leaving the window wipes it.
    always_comb begin
        if (!in_win) begin
            pend_d = 1'b0;
        end else if (kill) begin
            pend_d = 1'b0;
        end else begin
            pend_d = pend | set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            pend <= pend_d;
        end
    end

endmodule

// File: rtl/lpsi_fsm.sv
module lpsi_fsm
    import lpsi_pkg::*;
#(
    parameter int unsigned LEAD_CYC       = 440,
    parameter int unsigned MIN_ASSERT_CYC = 1,
    parameter int unsigned CW             = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          low_req,
    input  logic          high_req,
    input  logic          lo_pend,
    input  logic          hi_pend,
    input  logic [CW-1:0] cnt,
    output logic          tmr_clr,
    output logic          tmr_en,
    output logic          in_warn,
    output logic          in_hold,
    output logic          lp_ind_n,
    output logic          hi_grant
);

    localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_CYC - 1);

    lpsi_state_e state, state_nxt;
    logic        warn_done;
    logic        hold_done;
    logic        lo_take;
    logic        hi_take;

    assign warn_done = (cnt == LEAD_LAST);

    generate
        if (MIN_ASSERT_CYC <= 1) begin : g_hold_single
            assign hold_done = 1'b1;
        end else begin : g_hold_multi
            localparam logic [CW-1:0] HOLD_LAST = CW'(MIN_ASSERT_CYC - 1);
            assign hold_done = (cnt == HOLD_LAST);
        end
    endgenerate

    assign lo_take = (lo_pend | low_req) & ~high_req;
    assign hi_take = hi_pend | high_req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WARN;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WARN: begin
                if (warn_done) begin
                    state_nxt = lo_take ? ST_HOLD : ST_GRANT;
                end
            end
            ST_GRANT: begin
                if (low_req && !high_req) begin
                    state_nxt = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (hold_done) begin
                    state_nxt = hi_take ? ST_WARN : ST_LOW;
                end
            end
            ST_LOW: begin
                if (high_req) begin
                    state_nxt = ST_WARN;
                end
            end
            default: state_nxt = ST_WARN;
        endcase
    end

    // Output and control decode
    always_comb begin
        in_warn  = (state == ST_WARN);
        in_hold  = (state == ST_HOLD);
        lp_ind_n = ~state[1];
        hi_grant = (state == ST_GRANT);
        tmr_clr  = (state_nxt != state);
        tmr_en   = in_warn | in_hold;
    end

endmodule

// File: rtl/lpsi_ctrl.sv
module lpsi_ctrl
    import lpsi_pkg::*;
#(
    parameter int unsigned LEAD_CYC       = 440,
    parameter int unsigned MIN_ASSERT_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_req,
    input  logic high_req,
    output logic lp_ind_n,
    output logic hi_grant
);

    localparam int unsigned LIM = lpsi_max(LEAD_CYC, MIN_ASSERT_CYC);
    localparam int unsigned CW  = (LIM < 2) ? 1 : $clog2(LIM + 1);

    logic [CW-1:0] cnt;
    logic          tmr_clr;
    logic          tmr_en;
    logic          in_warn;
    logic          in_hold;
    logic          lo_pend;
    logic          hi_pend;

    lpsi_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .en    (tmr_en),
        .cnt   (cnt)
    );

    // Low request held through the lead window; high demand cancels it.
    lpsi_pend u_lo_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_win (in_warn),
        .set    (low_req & ~high_req),
        .kill   (high_req),
        .pend   (lo_pend)
    );

    // High request held through the minimum-assert window.
    lpsi_pend u_hi_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_win (in_hold),
        .set    (high_req),
        .kill   (1'b0),
        .pend   (hi_pend)
    );

    lpsi_fsm #(
        .LEAD_CYC       (LEAD_CYC),
        .MIN_ASSERT_CYC (MIN_ASSERT_CYC),
        .CW             (CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .low_req  (low_req),
        .high_req (high_req),
        .lo_pend  (lo_pend),
        .hi_pend  (hi_pend),
        .cnt      (cnt),
        .tmr_clr  (tmr_clr),
        .tmr_en   (tmr_en),
        .in_warn  (in_warn),
        .in_hold  (in_hold),
        .lp_ind_n (lp_ind_n),
        .hi_grant (hi_grant)
    );

endmodule

// File: rtl/lpsi_ctrl_chk.sv
module lpsi_ctrl_chk #(
    parameter int unsigned LEAD_CYC       = 440,
    parameter int unsigned MIN_ASSERT_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic low_req,
    input logic high_req,
    input logic lp_ind_n,
    input logic hi_grant
);

    // Run lengths of the indicator level, counted at the port.
    logic [31:0] hi_run;
    logic [31:0] lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= lp_ind_n  ? ((hi_run != '1) ? hi_run + 1 : hi_run) : '0;
            lo_run <= !lp_ind_n ? ((lo_run != '1) ? lo_run + 1 : lo_run) : '0;
        end
    end

    assert_grant_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_grant |-> lp_ind_n);

    assert_low_asserts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_grant && low_req && !high_req) |=> !lp_ind_n);

    assert_high_keeps_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_grant && high_req) |=> hi_grant);

    assert_high_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_ind_n && high_req && (lo_run + 1 >= MIN_ASSERT_CYC)) |=> lp_ind_n);

    assert_min_assert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_ind_n) |-> (lo_run >= MIN_ASSERT_CYC));

    assert_min_deassert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lp_ind_n) |-> (hi_run >= LEAD_CYC));

    assert_grant_lead_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_grant) |-> (hi_run >= LEAD_CYC));

endmodule

bind lpsi_ctrl lpsi_ctrl_chk #(
    .LEAD_CYC       (LEAD_CYC),
    .MIN_ASSERT_CYC (MIN_ASSERT_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .low_req  (low_req),
    .high_req (high_req),
    .lp_ind_n (lp_ind_n),
    .hi_grant (hi_grant)
);

// File: tb/sim_lpsi_ctrl.sv
module sim_lpsi_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LEAD       = 6;
    localparam int MINA       = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic low_req;
    logic high_req;
    logic lp_ind_n;
    logic hi_grant;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lpsi_ctrl #(.LEAD_CYC(LEAD), .MIN_ASSERT_CYC(MINA)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .low_req  (low_req),
        .high_req (high_req),
        .lp_ind_n (lp_ind_n),
        .hi_grant (hi_grant)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect2(input string req, input logic e_ind, input logic e_gnt);
        checks++;
        if (lp_ind_n !== e_ind) begin
            errors++;
            $display("FAIL %s lp_ind_n actual=%b expected=%b t=%0t", req, lp_ind_n, e_ind, $time);
        end
        checks++;
        if (hi_grant !== e_gnt) begin
            errors++;
            $display("FAIL %s hi_grant actual=%b expected=%b t=%0t", req, hi_grant, e_gnt, $time);
        end
        checks++;
        if (hi_grant === 1'b1 && lp_ind_n === 1'b0) begin
            errors++;
            $display("FAIL R2 grant with indicator asserted actual=11 expected=exclusive t=%0t", $time);
        end
    endtask

    // From GRANT: assert, then high request so WARN is entered at the last tick.
    task automatic enter_warn();
        low_req = 1'b1;
        tick();
        expect2("R3", 1'b0, 1'b0);
        low_req  = 1'b0;
        high_req = 1'b1;
        for (int i = 1; i <= MINA; i++) begin
            tick();
            expect2("R6", (i == MINA) ? 1'b1 : 1'b0, 1'b0);
        end
        high_req = 1'b0;
    endtask

    // Just entered HOLD: leave after the minimum and run to GRANT.
    task automatic back_to_grant();
        high_req = 1'b1;
        for (int i = 1; i <= MINA; i++) begin
            tick();
            expect2("R6", (i == MINA) ? 1'b1 : 1'b0, 1'b0);
        end
        high_req = 1'b0;
        for (int i = 1; i <= LEAD; i++) begin
            tick();
            expect2("R5", 1'b1, (i == LEAD) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        rst_n    = 1'b0;
        low_req  = 1'b0;
        high_req = 1'b0;
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            tick();
            expect2("R1", 1'b1, 1'b0);
        end
        rst_n = 1'b1;
        for (int i = 1; i <= LEAD; i++) begin
            tick();
            expect2("R1", 1'b1, (i == LEAD) ? 1'b1 : 1'b0);
        end

        // R4: high beats low while granted
        low_req  = 1'b1;
        high_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            expect2("R4", 1'b1, 1'b1);
        end
        high_req = 1'b0;
        tick();
        expect2("R3", 1'b0, 1'b0);
        low_req = 1'b0;

        // R9: dropping low while asserted has no effect
        for (int i = 0; i < MINA + 6; i++) begin
            tick();
            expect2("R9", 1'b0, 1'b0);
        end
        high_req = 1'b1;
        tick();
        expect2("R5", 1'b1, 1'b0);
        high_req = 1'b0;
        for (int i = 1; i <= LEAD; i++) begin
            tick();
            expect2("R5", 1'b1, (i == LEAD) ? 1'b1 : 1'b0);
        end

        // R6 / R5: sweep high arrival offset k after the asserting edge
        for (int pulse = 0; pulse < 2; pulse++) begin
            for (int k = 0; k <= ((pulse == 1) ? MINA - 2 : MINA + 1); k++) begin
                int r;
                r = (MINA > k + 1) ? MINA : k + 1;
                low_req = 1'b1;
                tick();
                expect2("R3", 1'b0, 1'b0);
                low_req = 1'b0;
                for (int t = 1; t <= k; t++) begin
                    tick();
                    expect2("R6", 1'b0, 1'b0);
                end
                high_req = 1'b1;
                for (int t = k + 1; t <= r; t++) begin
                    tick();
                    if (pulse == 1 && t == k + 1) high_req = 1'b0;
                    expect2("R6", (t == r) ? 1'b1 : 1'b0, 1'b0);
                end
                high_req = 1'b0;
                for (int i = 1; i <= LEAD; i++) begin
                    tick();
                    expect2("R5", 1'b1, (i == LEAD) ? 1'b1 : 1'b0);
                end
            end
        end

        // R7: low pulse at every offset of the lead window
        for (int k = 0; k < LEAD; k++) begin
            enter_warn();
            for (int t = 1; t <= LEAD; t++) begin
                if (t - 1 == k)     low_req = 1'b1;
                if (t - 1 == k + 1) low_req = 1'b0;
                tick();
                expect2("R7", (t == LEAD) ? 1'b0 : 1'b1, 1'b0);
            end
            low_req = 1'b0;
            back_to_grant();
        end

        // R8: low pulse then high pulse cancel inside the lead window
        for (int k = 0; k <= LEAD - 2; k++) begin
            enter_warn();
            for (int t = 1; t <= LEAD; t++) begin
                if (t - 1 == k) low_req = 1'b1;
                if (t - 1 == k + 1) begin
                    low_req  = 1'b0;
                    high_req = 1'b1;
                end
                if (t - 1 == k + 2) high_req = 1'b0;
                tick();
                expect2("R8", 1'b1, (t == LEAD) ? 1'b1 : 1'b0);
            end
            high_req = 1'b0;
            low_req  = 1'b0;
            tick();
            expect2("R10", 1'b1, 1'b1);
        end

        done = 1'b1;
        report();
    end

endmodule